// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer with Coherent Snapshot Reads

This block holds several independent down-counting timers behind a simple register bus made of an address, a write strobe with write data, and a read strobe with read data one cycle later. Each channel counts down from a programmable reload value and wraps back to it. On every wrap it bumps a per-channel wrap counter and sets a status bit. The status bit can drive a shared, maskable interrupt line. A global enable gates every channel, and each channel also has its own enable.

Software reads a channel as a pair. The wrap-count register is read first. That read also copies the live count into a per-channel snapshot. The counter register is read second and returns the snapshot, so the pair always describes the same instant. Until the next wrap-count read, the counter register keeps returning the old snapshot. With a reload of all ones, the bit-inverted snapshot is a free-running up-count that suits a system time base.

Top module: `multi_gptimer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The one exception is the revision register at 0x10, which reads the parameter `REV_ID`.
- R2: The control register at 0x00 holds the global enable in bit 0. While it is clear, no channel changes its count. Setting a channel's local enable still loads its reload value while the global enable is clear.
- R3: Channel n occupies a window at 0x20 + 0x20·n. Within the window the offsets are: local enable bit 0 at +0x00, reload at +0x04, counter at +0x08, wrap count at +0x0C, status bit 0 at +0x10, clear at +0x14, mask bit 0 at +0x18. Writing the local enable from 0 to 1 loads the reload value. Each clock with both enables set then lowers the count by one.
- R4: On a clock where the count is zero and the channel is ticking, the count reloads, the wrap counter rises by one and status bit 0 is set. The period is therefore reload+1 clocks.
- R5: Clearing the local enable freezes the count. Enabling again restarts from the reload value, and the wrap counter keeps its value.
- R6: A read of the wrap-count register returns the wrap counter and, on the same edge, copies the live count into the snapshot. A read of the counter register returns that snapshot, which counting does not change until the next wrap-count read. Read data is valid on the clock after the read strobe.
- R7: With a reload of 0xFFFFFFFF, the bit-inverted snapshot equals the number of ticks since the enable.
- R8: Writing a 1 to bit 0 of the clear register clears status bit 0, and writing a 0 there has no effect. If a wrap happens on the same clock as the clear, the status bit stays set.
- R9: `irq` is the OR over channels of status bit 0 AND mask bit 0. With the mask at 0 the status bit still records wraps.
- R10: Channels are independent: activity on one channel never changes another channel's count, wrap count or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters tick on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe; a wrap-count read also captures the snapshot |
| rd_data | output | DATA_W | Read data, valid the clock after `rd_en` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench checks that the counter register stays stale between wrap-count reads. A design that refreshed it on every clock would return a later value than the snapshot. It runs reload 0 so that every tick is a wrap, and checks the period of reload+1; an off-by-one here would shift both the frozen count and the wrap total. It drives a clear on the same clock as a wrap, where a design giving the clear priority would lose an event. It also sets the local enable while the global enable is off, which a design gating the load with the global enable would miss. Random reload values, run lengths and masks are checked against a counting model on all four channels. After each run the bench reads every channel, so that cross-channel disturbance shows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Offsets inside a channel window (behaviour depends on them via decode)
   localparam logic [4:0] OFS_CFG    = 5'h00;
   localparam logic [4:0] OFS_RELOAD = 5'h04;
   localparam logic [4:0] OFS_COUNT  = 5'h08;
   localparam logic [4:0] OFS_WRAPS  = 5'h0C;
   localparam logic [4:0] OFS_STAT   = 5'h10;
   localparam logic [4:0] OFS_CLR    = 5'h14;
   localparam logic [4:0] OFS_MASK   = 5'h18;
   // Top-level registers
   localparam int unsigned TOP_CTRL = 'h00;
   localparam int unsigned TOP_REV  = 'h10;
   localparam int unsigned WIN_BITS = 5;   // 32-byte window per channel

   typedef struct packed {
      logic       wr;
      logic       rd;
      logic [4:0] ofs;
   } chan_req_t;
endpackage

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int CNT_W = 32,
   parameter int OVF_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic [OVF_W-1:0] wraps,
   output logic             wrap
);
   assign wrap = tick && !load && (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         wraps <= '0;
      end else if (load) begin
         count <= reload_val;
      end else if (tick) begin
         if (count == '0) begin
            count <= reload_val;
            wraps <= wraps + 1'b1;
         end else begin
            count <= count - 1'b1;
         end
      end
   end

   // R3: a tick at a non-zero count lowers it by one
   a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count != '0) |=> (count == $past(count) - 1'b1));
   // R4: a tick at zero reloads and bumps the wrap counter
   a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == $past(reload_val) && wraps == $past(wraps) + 1'b1));
   // R2/R5: without tick or load the count holds
   a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int OVF_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_en,
   input  chan_req_t         req,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_out
);
   logic             loc_en_q, mask_q, stat_q;
   logic [CNT_W-1:0] reload_q, snap_q, count;
   logic [OVF_W-1:0] wraps;
   logic             load, tick, wrap, clr_hit, snap_take;

   assign load      = req.wr && req.ofs == OFS_CFG && wdata[0] && !loc_en_q;
   assign tick      = glob_en && loc_en_q;
   assign clr_hit   = req.wr && req.ofs == OFS_CLR && wdata[0];
   assign snap_take = req.rd && req.ofs == OFS_WRAPS;

   tmr_down_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .load       (load),
      .reload_val (reload_q),
      .count      (count),
      .wraps      (wraps),
      .wrap       (wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_en_q <= 1'b0;
         mask_q   <= 1'b0;
         reload_q <= '0;
      end else if (req.wr) begin
         case (req.ofs)
            OFS_CFG:    loc_en_q <= wdata[0];
            OFS_RELOAD: reload_q <= wdata[CNT_W-1:0];
            OFS_MASK:   mask_q   <= wdata[0];
            default:    ;
         endcase
      end
   end

   // status: an event on the same clock as a clear wins
   always_ff @(posedge clk) begin
      if (!rst_n)       stat_q <= 1'b0;
      else if (wrap)    stat_q <= 1'b1;
      else if (clr_hit) stat_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         snap_q <= '0;
      else if (snap_take) snap_q <= count;
   end

   always_comb begin
      rdata = '0;
      case (req.ofs)
         OFS_CFG:    rdata[0] = loc_en_q;
         OFS_RELOAD: rdata    = DATA_W'(reload_q);
         OFS_COUNT:  rdata    = DATA_W'(snap_q);
         OFS_WRAPS:  rdata    = DATA_W'(wraps);
         OFS_STAT:   rdata[0] = stat_q;
         OFS_MASK:   rdata[0] = mask_q;
         default:    rdata    = '0;
      endcase
   end

   assign irq_out = stat_q && mask_q;

   // R6: the snapshot only moves on a wrap-count read
   a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_take |=> $stable(snap_q));
   // R4: every wrap leaves the status bit set
   a_r4_status_set: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> stat_q);
   // R8: a clear without a competing wrap empties the status bit
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !wrap) |=> !stat_q);
   // R2: with the global enable off the wrap counter never moves
   a_r2_no_wrap_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> $stable(wraps));
endmodule

// File: rtl/multi_gptimer.sv
module multi_gptimer
   import tmr_pkg::*;
#(
   parameter int          NUM_CH = 4,
   parameter int          ADDR_W = 8,
   parameter int          DATA_W = 32,
   parameter int          CNT_W  = 32,
   parameter int          OVF_W  = 32,
   parameter logic [31:0] REV_ID = 32'h0001_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int WIN_W = ADDR_W - WIN_BITS;

   generate
      if (CNT_W > DATA_W || OVF_W > DATA_W) begin : g_bad_width
         $error("counter widths must fit the data bus");
      end
      if (NUM_CH < 1 || NUM_CH + 1 > (1 << WIN_W)) begin : g_bad_map
         $error("address bus too narrow for the channel windows");
      end
      if (DATA_W < 32) begin : g_bad_data
         $error("data bus must carry the revision word");
      end
   endgenerate

   logic                          glob_en_q;
   logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;
   logic [NUM_CH-1:0]             ch_irq;
   logic [WIN_W-1:0]              win;
   logic [4:0]                    ofs;
   logic [DATA_W-1:0]             rd_next;

   assign win = addr[ADDR_W-1:WIN_BITS];
   assign ofs = addr[WIN_BITS-1:0];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         chan_req_t req;
         logic      hit;
         assign hit     = (win == WIN_W'(gi + 1));
         assign req.wr  = wr_en && hit;
         assign req.rd  = rd_en && hit;
         assign req.ofs = ofs;

         tmr_channel #(.CNT_W(CNT_W), .OVF_W(OVF_W), .DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .glob_en (glob_en_q),
            .req     (req),
            .wdata   (wr_data),
            .rdata   (ch_rdata[gi]),
            .irq_out (ch_irq[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         glob_en_q <= 1'b0;
      else if (wr_en && addr == ADDR_W'(TOP_CTRL))
         glob_en_q <= wr_data[0];
   end

   always_comb begin
      rd_next = '0;
      if (win == '0) begin
         if (addr == ADDR_W'(TOP_CTRL))     rd_next[0] = glob_en_q;
         else if (addr == ADDR_W'(TOP_REV)) rd_next    = DATA_W'(REV_ID);
      end else begin
         for (int i = 0; i < NUM_CH; i++)
            if (win == WIN_W'(i + 1)) rd_next = ch_rdata[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end

   assign irq = |ch_irq;

   // R1: the line is low on the first clock after reset
   a_r1_irq_reset: assert property (@(posedge clk)
      !rst_n |=> !irq);
   // R6: read data only moves in response to a read strobe
   a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_multi_gptimer.sv
module tb_multi_gptimer;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam logic [31:0] REV = 32'h0001_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   longint unsigned cnt_e [NCH];
   longint unsigned ovf_e [NCH];
   bit              st_e  [NCH];
   bit              msk_e [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   multi_gptimer #(.REV_ID(REV)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [7:0] cb(int ch);
      return 8'(32 + 32 * ch);
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // each transaction starts at a falling edge and spends exactly one rising edge
   task automatic wr(logic [7:0] a, logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      d = rd_data; rd_en = 1'b0;
   endtask

   task automatic idle(int k);
      repeat (k) @(negedge clk);
   endtask

   // enable, let k more edges pass, disable: k+1 ticks from the reload value
   task automatic run_frozen(int ch, longint unsigned r, int k);
      longint unsigned n, p;
      wr(cb(ch) + 8'h04, 32'(r));
      wr(cb(ch), 32'h1);
      idle(k);
      wr(cb(ch), 32'h0);
      n = longint'(k) + 1;
      p = r + 1;
      ovf_e[ch] += n / p;
      if (n / p > 0) st_e[ch] = 1'b1;
      cnt_e[ch] = r - (n % p);
   endtask

   task automatic check_chan(int ch, string tag);
      logic [31:0] v;
      rd(cb(ch) + 8'h0C, v); chk({tag, " wraps"}, v, 32'(ovf_e[ch]));
      rd(cb(ch) + 8'h08, v); chk({tag, " count"}, v, 32'(cnt_e[ch]));
      rd(cb(ch) + 8'h10, v); chk({tag, " status"}, v, {31'b0, st_e[ch]});
   endtask

   function automatic bit irq_model();
      bit x = 1'b0;
      for (int i = 0; i < NCH; i++) x |= st_e[i] & msk_e[i];
      return x;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      void'($urandom(32'd1234));
      for (int i = 0; i < NCH; i++) begin
         cnt_e[i] = 0; ovf_e[i] = 0; st_e[i] = 0; msk_e[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
      rd(8'h10, v); chk("R1 revision", v, REV);
      for (int c = 0; c < NCH; c++) begin
         rd(cb(c) + 8'h04, v); chk("R1 reload", v, 32'h0);
         rd(cb(c) + 8'h18, v); chk("R1 mask", v, 32'h0);
         check_chan(c, "R1");
      end

      wr(8'h00, 32'h1);
      rd(8'h00, v); chk("R2 ctrl readback", v, 32'h1);

      // R3/R4 ch0: reload 5, 14 ticks -> 2 wraps, count 3
      run_frozen(0, 5, 13);
      check_chan(0, "R4 ch0 period");
      rd(cb(0), v); chk("R3 cfg readback", v, 32'h0);

      // R6 ch1: stale counter between wrap-count reads
      wr(cb(1) + 8'h04, 32'd100);
      wr(cb(1), 32'h1);
      idle(4);
      rd(cb(1) + 8'h0C, v); chk("R6 wraps live", v, 32'h0);
      idle(7);
      rd(cb(1) + 8'h08, v); chk("R6 stale snapshot", v, 32'd96);
      rd(cb(1) + 8'h0C, v);
      rd(cb(1) + 8'h08, v); chk("R6 refreshed snapshot", v, 32'd87);
      wr(cb(1), 32'h0);
      cnt_e[1] = 84;

      // R7 ch2: inverted up-count
      wr(cb(2) + 8'h04, 32'hFFFF_FFFF);
      wr(cb(2), 32'h1);
      idle(20);
      rd(cb(2) + 8'h0C, v);
      rd(cb(2) + 8'h08, v); chk("R7 inverted count", ~v, 32'd20);
      wr(cb(2), 32'h0);
      cnt_e[2] = 64'hFFFF_FFFF - 23;

      // R2 ch3: global enable stops counting
      wr(cb(3) + 8'h04, 32'd50);
      wr(cb(3), 32'h1);
      idle(3);
      wr(8'h00, 32'h0);
      idle(10);
      rd(cb(3) + 8'h0C, v);
      rd(cb(3) + 8'h08, v); chk("R2 frozen by global", v, 32'd46);
      wr(8'h00, 32'h1);
      idle(2);
      wr(cb(3), 32'h0);
      cnt_e[3] = 43;
      check_chan(3, "R2 resumed");
      // R2 local enable loads reload while global is off
      wr(8'h00, 32'h0);
      wr(cb(3) + 8'h04, 32'd9);
      wr(cb(3), 32'h1);
      idle(5);
      wr(cb(3), 32'h0);
      wr(8'h00, 32'h1);
      cnt_e[3] = 9;
      check_chan(3, "R2 load while global off");

      // R5 ch0: re-enable reloads, wrap count retained
      run_frozen(0, 5, 0);
      check_chan(0, "R5 re-enable");

      // R9 mask gating, R8 clear
      chk("R9 masked status no irq", {31'b0, irq}, 32'h0);
      wr(cb(0) + 8'h18, 32'h1); msk_e[0] = 1;
      chk("R9 unmasked irq", {31'b0, irq}, 32'h1);
      wr(cb(0) + 8'h14, 32'h0);
      rd(cb(0) + 8'h10, v); chk("R8 zero write ignored", v, 32'h1);
      wr(cb(0) + 8'h14, 32'h1); st_e[0] = 0;
      chk("R8 cleared irq", {31'b0, irq}, 32'h0);
      rd(cb(0) + 8'h10, v); chk("R8 cleared status", v, 32'h0);

      // R8 clear on the same clock as a wrap: reload 0, every tick wraps
      wr(cb(0) + 8'h04, 32'h0);
      wr(cb(0), 32'h1);
      idle(2);
      wr(cb(0) + 8'h14, 32'h1);
      wr(cb(0), 32'h0);
      ovf_e[0] += 4; cnt_e[0] = 0; st_e[0] = 1;
      check_chan(0, "R8 wrap beats clear");
      chk("R9 irq after wrap", {31'b0, irq}, {31'b0, irq_model()});

      // R10 other channels untouched
      for (int c = 1; c < NCH; c++) check_chan(c, "R10 idle channel");

      // random runs
      for (int t = 0; t < 30; t++) begin
         int ch = int'($urandom_range(NCH - 1, 0));
         longint unsigned r = longint'($urandom_range(23, 0));
         int k = int'($urandom_range(59, 0));
         bit m = 1'($urandom_range(1, 0));
         run_frozen(ch, r, k);
         wr(cb(ch) + 8'h18, {31'b0, m}); msk_e[ch] = m;
         chk("R9 random irq", {31'b0, irq}, {31'b0, irq_model()});
         for (int c = 0; c < NCH; c++) check_chan(c, "R10 random R4");
         if ($urandom_range(1, 0) == 1) begin
            wr(cb(ch) + 8'h14, 32'h1); st_e[ch] = 0;
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule